// File: doc/BRIEF.md
# Parallel-Port Register Access Engine

This block is the device half of a bridge that lets a host reach a disk drive's task-file registers through a plain parallel port. It supports three transfer modes. In all three the host writes a byte on the data lines and steps a 6-bit control value through a fixed sequence. The engine watches both. When it sees control value 1 while idle, it takes the data byte as a scrambled address. It descrambles that byte with a key that depends on the mode and on the direction. Bit 7 of the result picks one of two banks: the command bank when the bit is clear, the control bank when it is set.

On a write, the engine takes the next data byte when control goes to 3 and stores it in the selected register. On a read, it returns the register contents in a form that depends on the mode:
- two 4-bit halves on the status lines;
- five bits on the status lines plus three bits on the control readback lines;
- the whole byte driven onto the data lines.

Control value 4 always ends the access. The register banks here are a small behavioural model. Mode 3 is reserved, and the engine ignores all traffic while it is selected.

Top module: `pport_reg_engine`

## Requirements
- R1: After reset, `status_o`, `ctrl_rd_o`, `data_o` and `data_oe_o` are zero, and every register in both banks reads back as 0x00.
- R2: The address is captured only when the engine is idle and `ctrl_i` equals 0x01. After descrambling, bit 7 selects the bank (1 = control bank) and bits 2:0 select one of eight registers. A byte whose bits 6:3 are not all zero is not a valid address.
- R3: Read addresses are descrambled with the key for the current mode: mode 0 uses XOR 0x39, mode 1 uses XOR 0x31, mode 2 uses XOR 0x29.
- R4: In modes 0 to 2, an address XOR 0x19 starts a write. The engine stores `data_i` into the selected register on the cycle in which `ctrl_i` equals 0x03. A 0x03 that lasts a single clock is enough.
- R5: Mode 0 read. While `ctrl_i` is 0x03, `status_o[7:4]` holds data bits 3:0. Once 0x03 has been seen, and `ctrl_i` is anything else, `status_o[7:4]` holds data bits 7:4. `status_o[3:0]` and `ctrl_rd_o` stay zero.
- R6: Mode 1 read. Once `ctrl_i` has reached 0x05, `status_o[7:3]` holds data bits 4:0 and `ctrl_rd_o[3:1]` holds data bits 7:5. `status_o[2:0]` and `ctrl_rd_o[0]` stay zero.
- R7: Mode 2 read. `data_oe_o` is 1, and `data_o` carries the register byte, only while `ctrl_i` equals 0x23.
- R8: `ctrl_i` equal to 0x04 ends any access and returns the engine to idle. A write whose 0x03 strobe never arrived leaves the register unchanged. One cycle after 0x04 is sampled, all outputs are zero.
- R9: The following are ignored until the next 0x04: an address byte that matches neither key of the current mode, and any traffic in mode 3. Ignored traffic writes no register and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Transfer mode: 0 nibble, 1 split 5/3, 2 byte, 3 reserved |
| data_i | input | 8 | Host data byte |
| ctrl_i | input | 6 | Host control value |
| status_o | output | 8 | Status lines returned to the host |
| ctrl_rd_o | output | 4 | Control-port readback lines |
| data_o | output | 8 | Byte driven on the data lines in mode 2 |
| data_oe_o | output | 1 | Data-line drive enable |

## Verification
A register write can complete in the same cycle that the end-of-access value appears. The bench provokes this by holding control value 0x03 for exactly one clock before switching to 0x04. It then reads the register back through the normal read path, and the stored byte must be the new one. The opposite case is also exercised: the bench jumps straight from 0x01 to 0x04 with no strobe, and the readback must show the old value. Every register in both banks is written and read back in each of the three modes. A scoreboard compares each reassembled byte with a reference model.

// File: rtl/pport_reg_pkg.sv
package pport_reg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_HOLD} eng_st_e;

  localparam logic [5:0] CTL_ADDR  = 6'h01;
  localparam logic [5:0] CTL_STB   = 6'h03;
  localparam logic [5:0] CTL_END   = 6'h04;
  localparam logic [5:0] CTL_SPLIT = 6'h05;
  localparam logic [5:0] CTL_BYTE  = 6'h23;
  localparam logic [7:0] KEY_WR    = 8'h19;

  function automatic logic [7:0] rd_key(input logic [1:0] m);
    case (m)
      2'd0:    rd_key = 8'h39;
      2'd1:    rd_key = 8'h31;
      2'd2:    rd_key = 8'h29;
      default: rd_key = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pport_addr_decode.sv
module pport_addr_decode import pport_reg_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic [1:0]       mode_i,
  input  logic [7:0]       byte_i,
  output logic             rd_hit_o,
  output logic             wr_hit_o,
  output logic [IDX_W:0]   sel_o
);
  logic [7:0] rd_b, wr_b;
  logic       mode_ok;

  assign mode_ok  = (mode_i != 2'd3);
  assign rd_b     = byte_i ^ rd_key(mode_i);
  assign wr_b     = byte_i ^ KEY_WR;
  // bits between index and bank bit must be clear
  assign rd_hit_o = mode_ok && (rd_b[6:IDX_W] == '0);
  assign wr_hit_o = mode_ok && (wr_b[6:IDX_W] == '0);
  assign sel_o    = rd_hit_o ? {rd_b[7], rd_b[IDX_W-1:0]} : {wr_b[7], wr_b[IDX_W-1:0]};
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile #(
  parameter int IDX_W = 3,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W:0]   addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int NENT = 2 ** (IDX_W + 1);

  logic [DW-1:0] mem_q [NENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NENT; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/pport_read_fmt.sv
module pport_read_fmt import pport_reg_pkg::*; (
  input  logic [1:0] mode_i,
  input  logic [5:0] ctrl_i,
  input  logic       rd_act_i,
  input  logic       seen_stb_i,
  input  logic       seen_split_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] status_o,
  output logic [3:0] ctrl_rd_o,
  output logic [7:0] data_o,
  output logic       oe_o
);
  always_comb begin
    status_o  = '0;
    ctrl_rd_o = '0;
    data_o    = '0;
    oe_o      = 1'b0;
    if (rd_act_i && ctrl_i != CTL_END) begin
      case (mode_i)
        2'd0: begin
          if (ctrl_i == CTL_STB)  status_o = {rdata_i[3:0], 4'h0};
          else if (seen_stb_i)    status_o = {rdata_i[7:4], 4'h0};
        end
        2'd1: begin
          if (seen_split_i || ctrl_i == CTL_SPLIT) begin
            status_o  = {rdata_i[4:0], 3'b000};
            ctrl_rd_o = {rdata_i[7:5], 1'b0};
          end
        end
        2'd2: begin
          if (ctrl_i == CTL_BYTE) begin
            data_o = rdata_i;
            oe_o   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pport_reg_engine.sv
module pport_reg_engine import pport_reg_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [7:0] data_i,
  input  logic [5:0] ctrl_i,
  output logic [7:0] status_o,
  output logic [3:0] ctrl_rd_o,
  output logic [7:0] data_o,
  output logic       data_oe_o
);
  eng_st_e          st_q;
  logic [IDX_W:0]   sel_q, dec_sel;
  logic             rd_hit, wr_hit, seen_stb_q, seen_split_q, we;
  logic [7:0]       rdata, status_n, data_n;
  logic [3:0]       ctrl_rd_n;
  logic             oe_n;

  pport_addr_decode #(.IDX_W(IDX_W)) u_dec (
    .mode_i(mode_i), .byte_i(data_i),
    .rd_hit_o(rd_hit), .wr_hit_o(wr_hit), .sel_o(dec_sel)
  );

  assign we = (st_q == ST_WR) && (ctrl_i == CTL_STB);

  pport_regfile #(.IDX_W(IDX_W), .DW(8)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we),
    .addr_i(sel_q), .wdata_i(data_i), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      sel_q        <= '0;
      seen_stb_q   <= 1'b0;
      seen_split_q <= 1'b0;
    end else if (ctrl_i == CTL_END) begin
      st_q         <= ST_IDLE;
      seen_stb_q   <= 1'b0;
      seen_split_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (ctrl_i == CTL_ADDR) begin
          sel_q <= dec_sel;
          if (rd_hit)      st_q <= ST_RD;
          else if (wr_hit) st_q <= ST_WR;
          else             st_q <= ST_HOLD;
        end
        ST_RD: begin
          if (ctrl_i == CTL_STB)   seen_stb_q   <= 1'b1;
          if (ctrl_i == CTL_SPLIT) seen_split_q <= 1'b1;
        end
        ST_WR:   if (ctrl_i == CTL_STB) st_q <= ST_HOLD;
        default: ;
      endcase
    end
  end

  pport_read_fmt u_fmt (
    .mode_i(mode_i), .ctrl_i(ctrl_i), .rd_act_i(st_q == ST_RD),
    .seen_stb_i(seen_stb_q), .seen_split_i(seen_split_q), .rdata_i(rdata),
    .status_o(status_n), .ctrl_rd_o(ctrl_rd_n), .data_o(data_n), .oe_o(oe_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o  <= '0;
      ctrl_rd_o <= '0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      status_o  <= status_n;
      ctrl_rd_o <= ctrl_rd_n;
      data_o    <= data_n;
      data_oe_o <= oe_n;
    end
  end
endmodule

// File: rtl/pport_reg_engine_chk.sv
module pport_reg_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic [5:0] ctrl_i,
  input logic [7:0] status_o,
  input logic [3:0] ctrl_rd_o,
  input logic       data_oe_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  a_r7_oe_needs_byte_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && data_oe_o) |-> ($past(ctrl_i) == 6'h23 && $past(mode_i) == 2'd2));

  a_r8_end_quiets_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(ctrl_i) == 6'h04) |-> (status_o == 8'h00 && ctrl_rd_o == 4'h0 && !data_oe_o));

  a_r5_nibble_field_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(mode_i) == 2'd0) |-> (status_o[3:0] == 4'h0 && ctrl_rd_o == 4'h0 && !data_oe_o));

  a_r6_split_field_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(mode_i) == 2'd1) |-> (status_o[2:0] == 3'b000 && !ctrl_rd_o[0] && !data_oe_o));

  a_r9_reserved_mode_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(mode_i) == 2'd3) |-> (status_o == 8'h00 && ctrl_rd_o == 4'h0 && !data_oe_o));
endmodule

bind pport_reg_engine pport_reg_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .ctrl_i(ctrl_i),
  .status_o(status_o), .ctrl_rd_o(ctrl_rd_o), .data_oe_o(data_oe_o)
);

// File: tb/pport_reg_engine_tb_top.sv
`timescale 1ns/1ps
module pport_reg_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] data = 8'h00;
  logic [5:0] ctrl = 6'h04;
  logic [7:0] status, dout;
  logic [3:0] ctrl_rd;
  logic       oe;

  always #2 clk = ~clk;

  pport_reg_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .data_i(data), .ctrl_i(ctrl),
    .status_o(status), .ctrl_rd_o(ctrl_rd), .data_o(dout), .data_oe_o(oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] c);
    @(negedge clk); ctrl = c;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic int slot(input logic [7:0] idx);
    return {27'd0, idx[7], idx[2:0]};
  endfunction

  task automatic host_write(input logic [7:0] idx, input logic [7:0] val);
    data = idx ^ 8'h19; step(6'h01);
    data = val;         step(6'h03);
    step(6'h04);
  endtask

  task automatic host_read(input logic [7:0] idx, input string tag, output logic [7:0] v);
    logic [7:0] a, b;
    v = 8'h00;
    case (mode)
      2'd0: begin
        data = idx ^ 8'h39; step(6'h01); step(6'h03);
        a = status; step(6'h01); b = status;
        v = {b[7:4], a[7:4]};
      end
      2'd1: begin
        data = idx ^ 8'h31; step(6'h01);
        data = (idx ^ 8'h31) & 8'h37; step(6'h03); step(6'h05);
        data = (idx ^ 8'h31) | 8'hf0;
        @(negedge clk);
        v = {ctrl_rd[3:1], status[7:3]};
      end
      default: begin
        data = idx ^ 8'h29; step(6'h01); step(6'h21); step(6'h23);
        v = oe ? dout : 8'hxx;
      end
    endcase
    step(6'h04);
    chk(status == 8'h00 && ctrl_rd == 4'h0 && !oe, "R8 idle outputs", status, 8'h00);
  endtask

  task automatic sb_read(input logic [7:0] idx, input string tag);
    logic [7:0] v;
    exp_q.push_back(model[slot(idx)]);
    tag_q.push_back(tag);
    host_read(idx, tag, v);
    got_q.push_back(v);
  endtask

  // monitor: pops and compares reassembled bytes
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() != 0 && exp_q.size() != 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(g === e, t, g, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=00 exp=01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(status == 8'h00 && ctrl_rd == 4'h0 && !oe && dout == 8'h00, "R1 reset outputs", status, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mode = 2'd2;
    sb_read(8'h83, "R1 reset register");
    sb_read(8'h05, "R1 reset register");

    for (int m = 0; m < 3; m++) begin
      mode = m[1:0];
      for (int k = 0; k < 16; k++) begin
        logic [7:0] idx, val;
        idx = {k[3], 4'h0, k[2:0]};
        val = idx * 8'd37 + m[7:0] * 8'd91 + 8'd5;
        host_write(idx, val);
        model[slot(idx)] = val;
      end
      for (int k = 0; k < 16; k++) begin
        logic [7:0] idx;
        idx = {k[3], 4'h0, k[2:0]};
        case (m)
          0: sb_read(idx, "R5 R3 R2 nibble read");
          1: sb_read(idx, "R6 R3 R2 split read");
          default: sb_read(idx, "R7 R3 R2 byte read");
        endcase
      end
    end

    // write with a single-clock strobe immediately followed by end
    mode = 2'd0;
    data = 8'h02 ^ 8'h19; step(6'h01);
    data = 8'hc3;
    @(negedge clk); ctrl = 6'h03;
    @(negedge clk); ctrl = 6'h04;
    @(negedge clk); @(negedge clk);
    model[2] = 8'hc3;
    sb_read(8'h02, "R4 one-clock strobe");

    // write aborted before strobe
    data = 8'h82 ^ 8'h19; step(6'h01);
    data = 8'h5a; step(6'h04);
    sb_read(8'h82, "R8 aborted write");

    // unmatched key ignored
    mode = 2'd1;
    data = 8'h03 ^ 8'h55; step(6'h01);
    data = 8'hee; step(6'h03); step(6'h05);
    chk(status == 8'h00 && ctrl_rd == 4'h0, "R9 unmatched no output", status, 8'h00);
    step(6'h04);
    sb_read(8'h03, "R9 unmatched no write");

    // invalid index bits 6:3 set
    mode = 2'd0;
    host_write(8'h08, 8'h77);
    sb_read(8'h00, "R2 invalid index");

    // read key of another mode in mode 2
    mode = 2'd2;
    data = 8'h01 ^ 8'h39; step(6'h01); step(6'h21); step(6'h23);
    chk(!oe, "R3 foreign key no drive", {7'd0, oe}, 8'h00);
    step(6'h04);

    // mode 3 reserved
    mode = 2'd3;
    host_write(8'h04, 8'h99);
    data = 8'h04 ^ 8'h39; step(6'h01); step(6'h03);
    chk(status == 8'h00 && !oe, "R9 mode3 no output", status, 8'h00);
    step(6'h04);
    mode = 2'd2;
    sb_read(8'h04, "R9 mode3 no write");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule